// File: doc/BRIEF.md
# Vectored Interrupt Controller for a Small Microcontroller Core

This block gathers three interrupt sources for a small CPU: a programmable edge on an external pin, an overflow pulse from the timer, and any change on an 8-bit input port. It keeps a pending-flag register and an enable register, and the enable register carries a master enable bit. When a source is both pending and enabled while the master enable is on, the block gives the CPU a one-cycle request with the hardware vector 008h. In the same cycle it turns the master enable off, so a pending flag cannot re-enter the handler.

The CPU reports a software interrupt instruction through a strobe. The block answers with a request at vector 002h, whatever the master enable holds. The CPU reports a return-from-interrupt through a second strobe, which turns the master enable back on. Only software clears the flags. If a flag is still set and enabled when the master enable returns, the request is raised again at once.

While the CPU sleeps, a pending and enabled external-pin flag drives a wake output. The interrupt request itself still depends on the master enable. With the master enable on, the handler runs after wake-up. With it off, the CPU carries on at its next instruction. The pin and the port pass through two-flop synchronizers before any edge or change is detected.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags, all enables and the master enable read as zero, and take_irq and wake are low.
- R2: Reading the enable register (reg_sel=1) returns the timer enable in bit 0, the port enable in bit 1, the external-pin enable in bit 2 and the master enable in bit 7. Bits 3 to 6 read as zero.
- R3: A one-cycle tmr_ovf pulse sets flag bit 0 whatever its enable holds. If a flag-register write lands in the same cycle as the pulse, the set wins.
- R4: Reading the flag register (reg_sel=0) returns the flags ANDed bitwise with enable bits 0 to 2, and bits 3 to 7 read as zero.
- R5: When the master enable is on and some flag is set with its enable set, take_irq goes high for one cycle with vec_addr = 008h, and the master enable is cleared in the same cycle. No further hardware request follows until the master enable is set again.
- R6: A reti strobe sets the master enable. If a flag is still pending and enabled at that point, a new hardware request follows.
- R7: An sw_int strobe produces a take_irq pulse on the next cycle with vec_addr = 002h, whatever the master enable holds, and leaves the master enable unchanged. It takes priority over a hardware request in the same cycle.
- R8: Hardware never clears a flag. Only a write to the flag register clears one.
- R9: Flag bit 2 is set by a rising edge of ext_pin when edge_sel=1 and by a falling edge when edge_sel=0. The edge is detected after a two-flop synchronizer.
- R10: Flag bit 1 is set when the synchronized port value differs from its previous-cycle copy, and only while enable bit 1 is set. Changes made while that enable is clear are not recorded.
- R11: wake is high while sleep is high and flag bit 2 and enable bit 2 are both set. When the master enable is clear, no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle, synchronous |
| port_in | input | 8 | Input port watched for changes, asynchronous |
| edge_sel | input | 1 | 1 selects the rising edge of ext_pin, 0 selects the falling edge |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sw_int | input | 1 | Software interrupt instruction strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| sleep | input | 1 | CPU is sleeping |
| take_irq | output | 1 | One-cycle request to branch to vec_addr |
| vec_addr | output | 11 | Branch target, valid while take_irq is high |
| wake | output | 1 | Wake-up request while sleeping |

## Verification
The assertions assume that tmr_ovf, sw_int and reti are synchronous single-cycle strobes, and that the pin and the port are quiet during reset. They also assume that the CPU never issues sw_int and reti in the same cycle. The bench drives every strobe for exactly one cycle on the falling clock edge. It holds the asynchronous inputs low through reset, and it spaces stimulus so that each event has passed through the synchronizers before the next one starts. The random part keeps the master enable clear, so flag contents are checked on their own, and the directed cases cover requests, vectors and wake-up.

// File: rtl/ivc_pkg.sv
// Package for the interrupt controller: source bit positions, register
// selector encoding. Assumes three sources and an 8-bit register view.
package ivc_pkg;
    localparam int N_SRC    = 3;
    localparam int SRC_TMR  = 0;
    localparam int SRC_PORT = 1;
    localparam int SRC_EXT  = 2;
    localparam int GIE_POS  = 7;
    localparam int REG_W    = 8;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_EN   = 1'b1
    } regsel_e;
endpackage

// File: rtl/ivc_sync.sv
// Multi-stage synchronizer for an asynchronous input bus.
// Assumes each bit is independent (no coherent multi-bit capture needed).
module ivc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages shift the previous stage on
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ivc_detect.sv
// Edge detector for the external pin and change detector for the port.
// Works on synchronized inputs; detection is held off after reset until
// the synchronizer chain carries real samples.
module ivc_detect #(
    parameter int PORT_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic              edge_sel,
    output logic              ext_evt,
    output logic              port_evt
);
    logic              ext_prev;
    logic [PORT_W-1:0] port_prev;
    logic [STAGES:0]   arm_q;
    logic              armed;

    // Previous-cycle copies of the synchronized inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev  <= 1'b0;
            port_prev <= '0;
        end else begin
            ext_prev  <= ext_s;
            port_prev <= port_s;
        end
    end

    // Arming shift register: waits out the synchronizer fill after reset
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= {arm_q[STAGES-1:0], 1'b1};
    end

    assign armed    = arm_q[STAGES];
    assign ext_evt  = armed & (edge_sel ? (ext_s & ~ext_prev) : (~ext_s & ext_prev));
    assign port_evt = armed & (port_s != port_prev);
endmodule

// File: rtl/ivc_core.sv
// Flag/enable registers, master enable, request and vector generation,
// wake-up. Assumes tmr_evt, sw_int and reti are single-cycle strobes.
module ivc_core
    import ivc_pkg::*;
#(
    parameter int              ADDR_W = 11,
    parameter logic [ADDR_W-1:0] HW_VEC = 11'h008,
    parameter logic [ADDR_W-1:0] SW_VEC = 11'h002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_evt,
    input  logic              port_evt,
    input  logic              ext_evt,
    input  logic              reg_wr,
    input  regsel_e           reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              sw_int,
    input  logic              reti,
    input  logic              sleep,
    output logic              take_irq,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake
);
    logic [N_SRC-1:0]  flags_q, en_q, set_vec, flags_d;
    logic              gie_q, take_q, hw_pend, hw_take, flag_wr, en_wr;
    logic [ADDR_W-1:0] vec_q;
    logic              unused_wbits;

    assign flag_wr = reg_wr & (reg_sel == SEL_FLAG);
    assign en_wr   = reg_wr & (reg_sel == SEL_EN);

    // Event vector; the port source is gated by its own enable
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_TMR]  = tmr_evt;
        set_vec[SRC_PORT] = port_evt & en_q[SRC_PORT];
        set_vec[SRC_EXT]  = ext_evt;
    end

    // Next flags: software write, then events OR-ed on top (set wins)
    assign flags_d = (flag_wr ? reg_wdata[N_SRC-1:0] : flags_q) | set_vec;

    assign hw_pend = gie_q & (|(flags_q & en_q));
    assign hw_take = hw_pend & ~sw_int;

    // Flag register update
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // Per-source enable register update
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= reg_wdata[N_SRC-1:0];
    end

    // Master enable: taking clears, return sets, else software write
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (hw_take) gie_q <= 1'b0;
        else if (reti)    gie_q <= 1'b1;
        else if (en_wr)   gie_q <= reg_wdata[GIE_POS];
    end

    // Request pulse and vector select, software strobe first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= sw_int | hw_take;
            if (sw_int)       vec_q <= SW_VEC;
            else if (hw_take) vec_q <= HW_VEC;
        end
    end

    // Register read mux: flags are masked by their enables
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_FLAG) begin
            reg_rdata[N_SRC-1:0] = flags_q & en_q;
        end else begin
            reg_rdata[N_SRC-1:0] = en_q;
            reg_rdata[GIE_POS]   = gie_q;
        end
    end

    assign unused_wbits = ^reg_wdata[GIE_POS-1:N_SRC];
    assign take_irq     = take_q;
    assign vec_addr     = vec_q;
    assign wake         = sleep & flags_q[SRC_EXT] & en_q[SRC_EXT];

    AST_TIMER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> flags_q[SRC_TMR]); // R3

    for (genvar k = 0; k < N_SRC; k++) begin : g_hold
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[k] && !flag_wr |=> flags_q[k]); // R8
    end

    AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        hw_take |=> (!gie_q && take_q && vec_q == HW_VEC)); // R5

    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        reti && !hw_take |=> gie_q); // R6

    AST_SW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_int |=> (take_q && vec_q == SW_VEC)); // R7

    AST_PORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[SRC_PORT] && !flag_wr && !flags_q[SRC_PORT] |=> !flags_q[SRC_PORT]); // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the interrupt controller: synchronizes the pin and the port,
// detects events and feeds the register/request core.
// Assumes tmr_ovf is already in the clk domain.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int STAGES = 2,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_in,
    input  logic              edge_sel,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sw_int,
    input  logic              reti,
    input  logic              sleep,
    output logic              take_irq,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake
);
    logic              ext_s, ext_evt, port_evt;
    logic [PORT_W-1:0] port_s;
    regsel_e           sel_e;

    assign sel_e = regsel_e'(reg_sel);

    ivc_sync #(.W(1), .STAGES(STAGES)) i_sync_ext (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );

    ivc_sync #(.W(PORT_W), .STAGES(STAGES)) i_sync_port (
        .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s)
    );

    ivc_detect #(.PORT_W(PORT_W), .STAGES(STAGES)) i_detect (
        .clk(clk), .rst_n(rst_n), .ext_s(ext_s), .port_s(port_s),
        .edge_sel(edge_sel), .ext_evt(ext_evt), .port_evt(port_evt)
    );

    ivc_core #(.ADDR_W(ADDR_W), .HW_VEC(ADDR_W'(8)), .SW_VEC(ADDR_W'(2))) i_core (
        .clk(clk), .rst_n(rst_n),
        .tmr_evt(tmr_ovf), .port_evt(port_evt), .ext_evt(ext_evt),
        .reg_wr(reg_wr), .reg_sel(sel_e), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sw_int(sw_int), .reti(reti), .sleep(sleep),
        .take_irq(take_irq), .vec_addr(vec_addr), .wake(wake)
    );
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0, tmr_ovf = 1'b0, edge_sel = 1'b1;
    logic [7:0]  port_in = 8'h00;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        sw_int = 1'b0, reti = 1'b0, sleep = 1'b0;
    logic        take_irq, wake;
    logic [10:0] vec_addr;

    int n_run = 0, n_fail = 0, n_take = 0;
    logic [10:0] last_vec = '0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_in(port_in), .edge_sel(edge_sel), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sw_int(sw_int), .reti(reti), .sleep(sleep), .take_irq(take_irq),
        .vec_addr(vec_addr), .wake(wake)
    );

    // Request monitor, sampled away from the active edge
    always @(negedge clk) if (rst_n && take_irq) begin
        n_take++;
        last_vec = vec_addr;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    endtask
    task automatic pulse_sw();
        @(negedge clk); sw_int = 1'b1; @(negedge clk); sw_int = 1'b0;
    endtask
    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1; @(negedge clk); reti = 1'b0;
    endtask

    // Expected flag read from enables and which events occurred
    function automatic logic [7:0] exp_flags(logic [2:0] en, bit t, bit e, bit p);
        logic [2:0] f;
        f = {e, p & en[1], t};
        return {5'b0, f & en};
    endfunction

    initial begin
        logic [7:0] d;
        int takes0;
        void'($urandom(32'd20240611));
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        rd(1'b0, d); check("R1 flags after reset", d, 8'h00);
        rd(1'b1, d); check("R1 enables after reset", d, 8'h00);
        check("R1 take_irq low", take_irq, 0);
        check("R1 wake low", wake, 0);
        wait_cyc(4);

        // R3/R4: flag set with mask clear, hidden by AND on read
        pulse_tmr(); wait_cyc(2);
        rd(1'b0, d); check("R4 read masked by enables", d, 8'h00);
        wr(1'b1, 8'h01);
        rd(1'b0, d); check("R3 flag set with enable clear", d, 8'h01);
        // R3: set wins over same-cycle clear
        wr(1'b0, 8'h00);
        @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        @(negedge clk); reg_wr = 1'b0; tmr_ovf = 1'b0;
        rd(1'b0, d); check("R3 set beats write", d, 8'h01);
        // R2: unused enable bits read zero
        wr(1'b1, 8'h7F);
        rd(1'b1, d); check("R2 enable layout", d, 8'h07);
        wr(1'b1, 8'h00); wr(1'b0, 8'h00);

        // R5/R6/R8: request, recursion when the flag is left set
        takes0 = n_take;
        wr(1'b1, 8'h81);
        pulse_tmr(); wait_cyc(4);
        check("R5 one request", n_take - takes0, 1);
        check("R5 hardware vector", last_vec, 11'h008);
        rd(1'b1, d); check("R5 master enable cleared", d, 8'h01);
        wait_cyc(6);
        check("R5 no repeat while disabled", n_take - takes0, 1);
        rd(1'b0, d); check("R8 flag still set", d, 8'h01);
        pulse_reti(); wait_cyc(4);
        check("R6 re-request on pending flag", n_take - takes0, 2);
        wr(1'b0, 8'h00);
        pulse_reti(); wait_cyc(4);
        check("R6 no request once cleared", n_take - takes0, 2);
        rd(1'b1, d); check("R6 master enable set", d, 8'h81);

        // R7: software interrupt
        pulse_sw(); wait_cyc(2);
        check("R7 software request", n_take - takes0, 3);
        check("R7 software vector", last_vec, 11'h002);
        rd(1'b1, d); check("R7 master enable unchanged", d, 8'h81);
        wr(1'b1, 8'h00);
        pulse_sw(); wait_cyc(2);
        check("R7 request with master enable clear", n_take - takes0, 4);

        // R11/R9: wake-up from sleep on rising edge
        takes0 = n_take;
        wr(1'b1, 8'h04); wr(1'b0, 8'h00);
        @(negedge clk); sleep = 1'b1; edge_sel = 1'b1;
        wait_cyc(2);
        check("R11 no wake before edge", wake, 0);
        @(negedge clk); ext_pin = 1'b1;
        wait_cyc(8);
        check("R11 wake on enabled pin flag", wake, 1);
        check("R11 no request with master enable clear", n_take - takes0, 0);
        wr(1'b1, 8'h84); wait_cyc(3);
        check("R11 handler after enable", n_take - takes0, 1);
        check("R11 vector", last_vec, 11'h008);
        wr(1'b0, 8'h00); wait_cyc(1);
        check("R11 wake drops with flag", wake, 0);
        @(negedge clk); sleep = 1'b0;
        wr(1'b1, 8'h00);

        // R10: port change ignored while disabled, seen when enabled
        wr(1'b0, 8'h00);
        @(negedge clk); port_in = 8'hA5; wait_cyc(8);
        wr(1'b1, 8'h02);
        rd(1'b0, d); check("R10 change while disabled lost", d, 8'h00);
        @(negedge clk); port_in = 8'hA4; wait_cyc(8);
        rd(1'b0, d); check("R10 change while enabled", d, 8'h02);
        wr(1'b1, 8'h00); wr(1'b0, 8'h00);

        // Random mix of sources, masks and edge polarity (master enable off)
        for (int it = 0; it < 60; it++) begin
            logic [2:0] en;
            bit t, tg, esel, emat, pch;
            logic [7:0] np;
            en   = 3'($urandom);
            t    = 1'($urandom);
            tg   = 1'($urandom);
            esel = 1'($urandom);
            np   = ($urandom % 3 == 0) ? port_in : 8'($urandom);
            pch  = (np != port_in);
            emat = tg && ((esel && !ext_pin) || (!esel && ext_pin));
            wr(1'b1, {5'b0, en});
            @(negedge clk); edge_sel = esel;
            wait_cyc(4);
            wr(1'b0, 8'h00);
            @(negedge clk);
            tmr_ovf = t; port_in = np; ext_pin = ext_pin ^ tg;
            @(negedge clk); tmr_ovf = 1'b0;
            wait_cyc(8);
            rd(1'b0, d);
            check("R9 R10 R3 R4 random flag read", d, exp_flags(en, t, emat, pch));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule